// File: doc/BRIEF.md
# Flash bulk erase sequencer

This controller erases an entire byte-wide flash array from the host side. It first asks an external programmer whether every byte already holds 00h. If not, it asks that programmer to clear the array to 00h. Then it alternates erase pulses with per-byte verification. Each erase pulse is a set-up write of 20h followed by a second 20h write, and then a long settling wait. Verification of a byte is an A0h write carrying that byte's address, a short wait, and then a read whose result is compared with FFh.

Verification is incremental. A byte that reads FFh moves the pointer on. A byte that does not read FFh triggers one more erase pulse, and checking resumes at that same byte. Bytes already confirmed are not read again. The run ends with a write of 00h, which returns the array to read mode. It then reports pass when the last address verifies, or fail when a byte still does not read FFh after the final allowed pulse.

The programming-voltage ramp is represented by a ready input, which the sequencer waits on before it issues any request. All wait lengths and the pulse limit are parameters counted in clock cycles.

Top module: `flash_erase_seq`

## Requirements
- R1: Out of reset, busy_o, done_o, pass_o, fail_o, bus_wr_o, bus_rd_o and pre_req_o are all low.
- R2: A start_i pulse in idle begins a run, and no preprogram request is made while vpp_ready_i is low. A start_i pulse during a run has no effect: exactly one done_o pulse follows, and the outcome is unchanged.
- R3: The first request is a zero check (pre_req_o high, pre_prog_o low). If pre_zero_i is low when pre_ack_i arrives, a program request (pre_prog_o high) follows, otherwise none is made. pre_req_o stays high until pre_ack_i.
- R4: An erase pulse is two consecutive bus writes of 20h. The first pulse of a run starts with the pulse count at 1 and the verify address at 0.
- R5: The erase-verify write (data A0h, bus_addr_o = byte under test) comes exactly ERASE_WAIT+1 cycles after the second 20h write.
- R6: The verify read strobe comes exactly VERIFY_WAIT+1 cycles after the A0h write, at the same address.
- R7: A read of FFh advances the address by one. Any other value triggers a further erase pulse, and the next A0h write carries the same address again.
- R8: If a byte still fails on pulse MAX_PULSES, the run ends with fail. No more than MAX_PULSES erase pulses are issued per run.
- R9: When the last address (all ones) reads FFh, the run ends with pass, even if this happens on pulse MAX_PULSES.
- R10: The run ends with a bus write of 00h. In the next cycle done_o pulses for one cycle. Exactly one of pass_o or fail_o is then held high until the next start.
- R11: bus_wr_o and bus_rd_o are never high together, and the write data is always one of 00h, 20h or A0h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start a run (pulse) |
| vpp_ready_i | input | 1 | Programming voltage has settled |
| pre_req_o | output | 1 | Request to external programmer |
| pre_prog_o | output | 1 | 0 = zero check, 1 = program all bytes to 00h |
| pre_ack_i | input | 1 | Programmer acknowledge (one cycle) |
| pre_zero_i | input | 1 | With ack of a check: array is all 00h |
| bus_wr_o | output | 1 | Bus write strobe |
| bus_rd_o | output | 1 | Bus read strobe |
| bus_addr_o | output | ADDR_W | Bus address |
| bus_wdata_o | output | 8 | Bus write data (command byte) |
| bus_rdata_i | input | 8 | Bus read data |
| bus_rvalid_i | input | 1 | Read data valid |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | Run finished (one-cycle pulse) |
| pass_o | output | 1 | Array verified erased |
| fail_o | output | 1 | Pulse limit reached with a failing byte |

## Verification
The critical coincidence is the pulse-limit decision and the last-address pass decision landing on the same verify read. This happens when the final byte first reads FFh only after pulse MAX_PULSES. The bench builds a flash model in which that byte needs exactly MAX_PULSES pulses. The run must then report pass with MAX_PULSES pulses counted. A neighbouring case, where the byte needs one more pulse, must report fail with the same pulse count.

// File: rtl/flash_erase_pkg.sv
package flash_erase_pkg;
  localparam logic [7:0] CMD_READ   = 8'h00;
  localparam logic [7:0] CMD_ERASE  = 8'h20;
  localparam logic [7:0] CMD_EVERIF = 8'hA0;
  localparam logic [7:0] BYTE_ERASED = 8'hFF;

  typedef enum logic [3:0] {
    ST_IDLE, ST_VPP, ST_CHK, ST_PGM, ST_ESET, ST_EGO, ST_EWAIT,
    ST_VCMD, ST_VWAIT, ST_VRD, ST_VDAT, ST_FIN
  } fe_state_e;
endpackage

// File: rtl/flash_erase_timer.sv
module flash_erase_timer #(
  parameter int TW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [TW-1:0] load_val_i,
  output logic          zero_o
);
  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= load_val_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/flash_erase_fsm.sv
module flash_erase_fsm
  import flash_erase_pkg::*;
#(
  parameter int ADDR_W      = 17,
  parameter int MAX_PULSES  = 1000,
  parameter int ERASE_WAIT  = 1000000,
  parameter int VERIFY_WAIT = 600,
  parameter int PW          = 10,
  parameter int TW          = 20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              vpp_ready_i,
  output logic              pre_req_o,
  output logic              pre_prog_o,
  input  logic              pre_ack_i,
  input  logic              pre_zero_i,
  output logic              bus_wr_o,
  output logic              bus_rd_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [7:0]        bus_wdata_o,
  input  logic [7:0]        bus_rdata_i,
  input  logic              bus_rvalid_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              pass_o,
  output logic              fail_o,
  output logic [PW-1:0]     pulse_o,
  output logic              tmr_load_o,
  output logic [TW-1:0]     tmr_val_o,
  input  logic              tmr_zero_i
);
  localparam logic [ADDR_W-1:0] LAST_ADDR = '1;
  localparam logic [PW-1:0]     PULSE_CAP = PW'(MAX_PULSES);
  localparam logic [TW-1:0]     EW_LOAD   = TW'(ERASE_WAIT - 1);
  localparam logic [TW-1:0]     VW_LOAD   = TW'(VERIFY_WAIT - 1);

  fe_state_e         state_q, state_d;
  logic [ADDR_W-1:0] addr_q;
  logic [PW-1:0]     pulse_q;
  logic              verdict_q, done_q, pass_q, fail_q;
  logic              byte_ok;

  assign byte_ok = (bus_rdata_i == BYTE_ERASED);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (start_i) state_d = ST_VPP;
      ST_VPP:   if (vpp_ready_i) state_d = ST_CHK;
      ST_CHK:   if (pre_ack_i) state_d = pre_zero_i ? ST_ESET : ST_PGM;
      ST_PGM:   if (pre_ack_i) state_d = ST_ESET;
      ST_ESET:  state_d = ST_EGO;
      ST_EGO:   state_d = ST_EWAIT;
      ST_EWAIT: if (tmr_zero_i) state_d = ST_VCMD;
      ST_VCMD:  state_d = ST_VWAIT;
      ST_VWAIT: if (tmr_zero_i) state_d = ST_VRD;
      ST_VRD:   state_d = ST_VDAT;
      ST_VDAT: begin
        if (bus_rvalid_i) begin
          if (byte_ok) state_d = (addr_q == LAST_ADDR) ? ST_FIN : ST_VCMD;
          else         state_d = (pulse_q == PULSE_CAP) ? ST_FIN : ST_ESET;
        end
      end
      ST_FIN:   state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      addr_q    <= '0;
      pulse_q   <= '0;
      verdict_q <= 1'b0;
      done_q    <= 1'b0;
      pass_q    <= 1'b0;
      fail_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= 1'b0;
      case (state_q)
        ST_IDLE: if (start_i) begin
          pass_q <= 1'b0;
          fail_q <= 1'b0;
        end
        ST_CHK, ST_PGM: if (state_d == ST_ESET) begin
          addr_q  <= '0;
          pulse_q <= PW'(1);
        end
        ST_VDAT: if (bus_rvalid_i) begin
          if (byte_ok) begin
            if (addr_q == LAST_ADDR) verdict_q <= 1'b1;
            else                     addr_q    <= addr_q + 1'b1;
          end else if (pulse_q == PULSE_CAP) begin
            verdict_q <= 1'b0;
          end else begin
            pulse_q <= pulse_q + 1'b1;  // verification resumes at addr_q
          end
        end
        ST_FIN: begin
          done_q <= 1'b1;
          pass_q <= verdict_q;
          fail_q <= !verdict_q;
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    bus_wr_o    = 1'b0;
    bus_wdata_o = CMD_READ;
    unique case (state_q)
      ST_ESET, ST_EGO: begin bus_wr_o = 1'b1; bus_wdata_o = CMD_ERASE;  end
      ST_VCMD:         begin bus_wr_o = 1'b1; bus_wdata_o = CMD_EVERIF; end
      ST_FIN:          begin bus_wr_o = 1'b1; bus_wdata_o = CMD_READ;   end
      default: ;
    endcase
  end

  assign bus_rd_o   = (state_q == ST_VRD);
  assign bus_addr_o = addr_q;
  assign pre_req_o  = (state_q == ST_CHK) || (state_q == ST_PGM);
  assign pre_prog_o = (state_q == ST_PGM);
  assign busy_o     = (state_q != ST_IDLE);
  assign done_o     = done_q;
  assign pass_o     = pass_q;
  assign fail_o     = fail_q;
  assign pulse_o    = pulse_q;
  assign tmr_load_o = (state_q == ST_EGO) || (state_q == ST_VCMD);
  assign tmr_val_o  = (state_q == ST_EGO) ? EW_LOAD : VW_LOAD;
endmodule

// File: rtl/flash_erase_seq.sv
module flash_erase_seq #(
  parameter int ADDR_W      = 17,
  parameter int MAX_PULSES  = 1000,
  parameter int ERASE_WAIT  = 1000000,
  parameter int VERIFY_WAIT = 600
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              vpp_ready_i,
  output logic              pre_req_o,
  output logic              pre_prog_o,
  input  logic              pre_ack_i,
  input  logic              pre_zero_i,
  output logic              bus_wr_o,
  output logic              bus_rd_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [7:0]        bus_wdata_o,
  input  logic [7:0]        bus_rdata_i,
  input  logic              bus_rvalid_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              pass_o,
  output logic              fail_o
);
  localparam int PW   = $clog2(MAX_PULSES + 1);
  localparam int WMAX = (ERASE_WAIT > VERIFY_WAIT) ? ERASE_WAIT : VERIFY_WAIT;
  localparam int TW   = $clog2(WMAX + 1);

  logic [PW-1:0] pulse_cnt;
  logic          tmr_load, tmr_zero;
  logic [TW-1:0] tmr_val;

  flash_erase_fsm #(
    .ADDR_W(ADDR_W), .MAX_PULSES(MAX_PULSES), .ERASE_WAIT(ERASE_WAIT),
    .VERIFY_WAIT(VERIFY_WAIT), .PW(PW), .TW(TW)
  ) u_fsm (
    .clk_i, .rst_ni, .start_i, .vpp_ready_i,
    .pre_req_o, .pre_prog_o, .pre_ack_i, .pre_zero_i,
    .bus_wr_o, .bus_rd_o, .bus_addr_o, .bus_wdata_o, .bus_rdata_i, .bus_rvalid_i,
    .busy_o, .done_o, .pass_o, .fail_o,
    .pulse_o(pulse_cnt), .tmr_load_o(tmr_load), .tmr_val_o(tmr_val),
    .tmr_zero_i(tmr_zero)
  );

  flash_erase_timer #(.TW(TW)) u_tmr (
    .clk_i, .rst_ni, .load_i(tmr_load), .load_val_i(tmr_val), .zero_o(tmr_zero)
  );
endmodule

// File: rtl/flash_erase_chk.sv
module flash_erase_chk #(
  parameter int MAX_PULSES = 1000,
  parameter int PW         = 10
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          bus_wr_i,
  input logic          bus_rd_i,
  input logic [7:0]    bus_wdata_i,
  input logic          pre_req_i,
  input logic          pre_ack_i,
  input logic          done_i,
  input logic          pass_i,
  input logic          fail_i,
  input logic [PW-1:0] pulse_i
);
  AST_BUS_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(bus_wr_i && bus_rd_i)); // R11
  AST_WDATA_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_wr_i |-> (bus_wdata_i == 8'h00 || bus_wdata_i == 8'h20 || bus_wdata_i == 8'hA0)); // R11
  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pre_req_i && !pre_ack_i) |=> pre_req_i); // R3
  AST_PULSE_CAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_i <= PW'(MAX_PULSES)); // R8
  AST_DONE_AFTER_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_i) |-> ($past(bus_wr_i) && $past(bus_wdata_i) == 8'h00)); // R10
  AST_VERDICT_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(pass_i && fail_i)); // R10
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> !done_i); // R10
endmodule

bind flash_erase_seq flash_erase_chk #(.MAX_PULSES(MAX_PULSES), .PW(PW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .bus_wr_i(bus_wr_o), .bus_rd_i(bus_rd_o),
  .bus_wdata_i(bus_wdata_o), .pre_req_i(pre_req_o), .pre_ack_i(pre_ack_i),
  .done_i(done_o), .pass_i(pass_o), .fail_i(fail_o), .pulse_i(pulse_cnt)
);

// File: tb/flash_erase_seq_tb.sv
module flash_erase_seq_tb;
  localparam int AW = 4;
  localparam int DEPTH = 1 << AW;
  localparam int MAXP = 6;
  localparam int EW = 12;
  localparam int VW = 3;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic start_i = 1'b0, vpp_ready_i = 1'b0;
  logic pre_req_o, pre_prog_o, pre_ack_i = 1'b0, pre_zero_i = 1'b0;
  logic bus_wr_o, bus_rd_o, bus_rvalid_i = 1'b0;
  logic [AW-1:0] bus_addr_o;
  logic [7:0] bus_wdata_o, bus_rdata_i = 8'h00;
  logic busy_o, done_o, pass_o, fail_o;

  always #5 clk_i = ~clk_i;

  flash_erase_seq #(.ADDR_W(AW), .MAX_PULSES(MAXP), .ERASE_WAIT(EW), .VERIFY_WAIT(VW)) u_dut (
    .clk_i, .rst_ni, .start_i, .vpp_ready_i, .pre_req_o, .pre_prog_o, .pre_ack_i, .pre_zero_i,
    .bus_wr_o, .bus_rd_o, .bus_addr_o, .bus_wdata_o, .bus_rdata_i, .bus_rvalid_i,
    .busy_o, .done_o, .pass_o, .fail_o
  );

  int tests = 0, fails = 0;
  int need [DEPTH];
  int zero_cfg;
  // model / monitor state
  int cyc = 0, pulses = 0, reads = 0, chk_seen = 0, prog_seen = 0, done_seen = 0;
  int gap_err = 0, addr_err = 0, order_err = 0, early_req = 0;
  int erase_t = 0, a0_t = 0, rd_lat = 0, pre_wait = 0;
  bit setup_pend = 0, after_erase = 0, first_a0 = 1, pulse_since = 0, done_ok = 1;
  logic [AW-1:0] vaddr = '0;
  logic [7:0] last_wd = 8'h00;
  int last_wr_t = -5;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(negedge clk_i) begin
    cyc++;
    bus_rvalid_i = 1'b0;
    if (!vpp_ready_i && pre_req_o) early_req++;
    if (pre_ack_i) pre_ack_i = 1'b0;
    else if (pre_req_o) begin
      pre_wait++;
      if (pre_wait == 2) begin
        pre_wait = 0;
        pre_ack_i = 1'b1;
        pre_zero_i = zero_cfg[0];
        if (pre_prog_o) prog_seen++; else chk_seen++;
      end
    end
    if (bus_wr_o) begin
      if (bus_wdata_o == 8'h20) begin
        if (setup_pend) begin
          setup_pend = 0; pulses++; erase_t = cyc; after_erase = 1; pulse_since = 1;
        end else setup_pend = 1;
      end else begin
        if (setup_pend) order_err++;
        setup_pend = 0;
      end
      if (bus_wdata_o == 8'hA0) begin
        if (after_erase && (cyc - erase_t != EW + 1)) gap_err++;
        after_erase = 0;
        a0_t = cyc;
        if (first_a0) begin if (bus_addr_o != '0) addr_err++; end
        else if (pulse_since) begin if (bus_addr_o != vaddr) addr_err++; end
        else if (bus_addr_o != vaddr + 1'b1) addr_err++;
        first_a0 = 0; pulse_since = 0;
        vaddr = bus_addr_o;
      end
      last_wd = bus_wdata_o; last_wr_t = cyc;
    end
    if (rd_lat != 0) begin
      rd_lat--;
      if (rd_lat == 0) begin
        bus_rvalid_i = 1'b1;
        bus_rdata_i = (pulses >= need[vaddr]) ? 8'hFF : 8'($urandom_range(0, 8'hFE));
      end
    end
    if (bus_rd_o) begin
      reads++;
      if (cyc - a0_t != VW + 1 || bus_addr_o != vaddr) gap_err++;
      rd_lat = $urandom_range(1, 3);
    end
    if (done_o) begin
      done_seen++;
      if (!(last_wd == 8'h00 && last_wr_t == cyc - 1)) done_ok = 0;
    end
  end

  task automatic run_case(input string name, input int zc, input bit restart_mid);
    int mx = 0, exp_p;
    bit exp_pass;
    for (int a = 0; a < DEPTH; a++) if (need[a] > mx) mx = need[a];
    exp_pass = (mx <= MAXP);
    exp_p = exp_pass ? ((mx < 1) ? 1 : mx) : MAXP;
    zero_cfg = zc;
    pulses = 0; reads = 0; chk_seen = 0; prog_seen = 0; done_seen = 0;
    gap_err = 0; addr_err = 0; order_err = 0; early_req = 0;
    setup_pend = 0; after_erase = 0; first_a0 = 1; pulse_since = 0; done_ok = 1;
    @(negedge clk_i);
    vpp_ready_i = 1'b0;
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    repeat (4) @(negedge clk_i);
    check(busy_o && early_req == 0, {name, " R2 no request before vpp ready"}, early_req, 0);
    vpp_ready_i = 1'b1;
    if (restart_mid) begin
      repeat (40) @(negedge clk_i);
      start_i = 1'b1;
      @(negedge clk_i);
      start_i = 1'b0;
    end
    while (!done_o) @(negedge clk_i);
    @(negedge clk_i);
    @(negedge clk_i);
    check(done_seen == 1, {name, " R2/R10 one done pulse"}, done_seen, 1);
    check(chk_seen == 1, {name, " R3 one zero check"}, chk_seen, 1);
    check(prog_seen == (zc ? 0 : 1), {name, " R3 program request"}, prog_seen, zc ? 0 : 1);
    check(order_err == 0, {name, " R4 paired 20h writes"}, order_err, 0);
    check(gap_err == 0, {name, " R5/R6 wait gaps"}, gap_err, 0);
    check(addr_err == 0, {name, " R7 verify address resume"}, addr_err, 0);
    check(pulses == exp_p, {name, " R8/R9 pulse count"}, pulses, exp_p);
    check(pass_o == exp_pass && fail_o == !exp_pass,
          {name, exp_pass ? " R9 pass" : " R8 fail"}, {pass_o, fail_o}, {exp_pass, !exp_pass});
    check(done_ok, {name, " R10 00h write before done"}, done_ok, 1);
    if (exp_pass)
      check(reads == DEPTH + exp_p - 1, {name, " R7 read count"}, reads, DEPTH + exp_p - 1);
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk_i);
    check(!busy_o && !done_o && !pass_o && !fail_o && !bus_wr_o && !bus_rd_o && !pre_req_o,
          "R1 reset state", {busy_o, done_o, pass_o, fail_o, bus_wr_o, bus_rd_o, pre_req_o}, 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    check(!busy_o && !pass_o && !fail_o, "R1 idle after reset", busy_o, 0);

    for (int a = 0; a < DEPTH; a++) need[a] = 1;
    run_case("all-one", 1, 0);
    for (int a = 0; a < DEPTH; a++) need[a] = $urandom_range(0, 4);
    run_case("preprog", 0, 1);
    for (int a = 0; a < DEPTH; a++) need[a] = $urandom_range(0, MAXP - 1);
    need[DEPTH-1] = MAXP;
    run_case("limit-pass", 1, 0);
    for (int a = 0; a < DEPTH; a++) need[a] = $urandom_range(0, 2);
    need[DEPTH/2] = MAXP + 1;
    run_case("limit-fail", 0, 0);
    for (int k = 0; k < 6; k++) begin
      for (int a = 0; a < DEPTH; a++)
        need[a] = ($urandom_range(0, 15) == 0) ? MAXP + 1 : $urandom_range(0, MAXP);
      run_case("random", int'($urandom_range(0, 1)), k[0]);
    end
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    tests++;
    fails++;
    $display("FAIL watchdog expired actual=hang expected=done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule